// File: doc/BRIEF.md
# Burst Address Sequencer

This block produces the word address that a burst memory array sees during a four-beat access. A full starting address is captured from an external bus under one of two active-low load strobes. One strobe belongs to a cache controller and always loads. The other belongs to a processor and is honoured only while an active-low chip enable is asserted. After the load, an active-low advance strobe steps the two least significant address bits through a four-beat sequence. The upper address bits stay frozen for as long as the burst lasts.

The beat order is chosen by a static order-select input. It picks either an interleaved order, in which beat k is the starting low bits XOR k, or a linear order, in which the low bits count up modulo four from the start. When the advance strobe is inactive, the address is held and the burst is suspended. After the fourth beat the sequence returns to the loaded start address and never carries into the upper bits.

Top module: `burst_addr_seq`

## Requirements
- R1: A synchronous reset (rst high on a rising edge) drives addrOut to all zeros. The next advance then steps from a base of zero in linear order.
- R2: When cacheLoadN is low on a rising edge, addrIn is captured and appears on addrOut after that edge, whatever the level of chipEnN.
- R3: When procLoadN is low on a rising edge, addrIn is captured only if chipEnN is also low. With chipEnN high the processor strobe has no effect.
- R4: On edges without a load, the upper bits addrOut[ADDR_W-1:2] keep their loaded value, even while addrIn changes.
- R5: On an edge with no load and advanceN high, addrOut keeps its value.
- R6: With interleaved order (orderIl = 1 at load time), the low bits of beat k are the starting low bits XOR k. For example, start 01 gives 01, 00, 11, 10.
- R7: With linear order (orderIl = 0 at load time), the low bits of beat k are (start + k) mod 4. For example, start 10 gives 10, 11, 00, 01.
- R8: An advance after the fourth beat returns the low bits to the loaded start value. No carry reaches the upper bits.
- R9: A load on the same edge as an advance takes priority. addrOut becomes the new addrIn and the beat index restarts at zero.
- R10: orderIl is sampled only on load edges. A change of orderIl during a burst does not alter that burst's order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; every register updates on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| addrIn | input | ADDR_W | External starting address |
| procLoadN | input | 1 | Processor load strobe, active low, qualified by chipEnN |
| cacheLoadN | input | 1 | Cache-controller load strobe, active low, unqualified |
| chipEnN | input | 1 | Chip enable, active low; gates procLoadN only |
| advanceN | input | 1 | Burst advance strobe, active low |
| orderIl | input | 1 | Order select: 1 interleaved, 0 linear; captured at load |
| addrOut | output | ADDR_W | Current word address driven to the array |

## Verification
The assertions check four rules on every cycle. The upper bits never move without a load. A non-load cycle with the advance strobe inactive holds the whole address. Any load puts the bus value on the output one edge later. A linear-mode advance adds exactly one to the low bits. Other behaviour needs the bench's scenarios and its cycle-by-cycle model. Those scenarios cover the complete interleaved and linear sequences from different start values, the wrap back to the start, the processor strobe being ignored while the chip is not enabled, a load colliding with an advance, an order-select change in mid-burst, and a reset in mid-burst.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
  // Width of the stepping part of the address: four beats per burst.
  localparam int BEAT_W = 2;

  // Strobes issued by the control decode to the datapath each cycle.
  typedef struct packed {
    logic load;     // capture a new base address and restart the beat index
    logic advance;  // step the beat index (never set together with load)
  } seqStrobes_t;
endpackage

// File: rtl/burst_seq_ctrl.sv
module burst_seq_ctrl
  import burst_seq_pkg::*;
(
  input  logic        procLoadN,
  input  logic        cacheLoadN,
  input  logic        chipEnN,
  input  logic        advanceN,
  output seqStrobes_t strobes
);
  logic cacheLoad;
  logic procLoad;

  always_comb begin
    cacheLoad       = !cacheLoadN;
    // The processor strobe only counts while the chip is enabled.
    procLoad        = !procLoadN && !chipEnN;
    strobes.load    = cacheLoad || procLoad;
    // A load wins over an advance on the same edge.
    strobes.advance = !advanceN && !strobes.load;
  end
endmodule

// File: rtl/burst_order_map.sv
module burst_order_map #(
  parameter int BEAT_W = 2
) (
  input  logic [BEAT_W-1:0] baseLow,
  input  logic [BEAT_W-1:0] beatIdx,
  input  logic              interleave,
  output logic [BEAT_W-1:0] beatAddr
);
  logic [BEAT_W-1:0] xorForm;
  logic [BEAT_W-1:0] sumForm;

  always_comb begin
    xorForm  = baseLow ^ beatIdx;
    // The sum truncates to BEAT_W bits, so the linear order wraps modulo 2**BEAT_W.
    sumForm  = baseLow + beatIdx;
    beatAddr = interleave ? xorForm : sumForm;
  end
endmodule

// File: rtl/burst_seq_dp.sv
module burst_seq_dp
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W = 18
) (
  input  logic              clk,
  input  logic              rst,
  input  seqStrobes_t       strobes,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic              orderIl,
  output logic [ADDR_W-1:0] addrOut
);
  localparam int UPPER_W = ADDR_W - BEAT_W;

  logic [UPPER_W-1:0] upperQ;
  logic [BEAT_W-1:0]  baseLowQ;
  logic [BEAT_W-1:0]  beatIdxQ;
  logic               modeIlQ;
  logic [BEAT_W-1:0]  beatAddr;

  always_ff @(posedge clk) begin
    if (rst) begin
      upperQ   <= '0;
      baseLowQ <= '0;
      beatIdxQ <= '0;
      modeIlQ  <= 1'b0;
    end else if (strobes.load) begin
      upperQ   <= addrIn[ADDR_W-1:BEAT_W];
      baseLowQ <= addrIn[BEAT_W-1:0];
      beatIdxQ <= '0;
      modeIlQ  <= orderIl;
    end else if (strobes.advance) begin
      // The index wraps at BEAT_W bits, so the burst returns to its start.
      beatIdxQ <= beatIdxQ + 1'b1;
    end
  end

  burst_order_map #(.BEAT_W(BEAT_W)) i_map (
    .baseLow    (baseLowQ),
    .beatIdx    (beatIdxQ),
    .interleave (modeIlQ),
    .beatAddr   (beatAddr)
  );

  assign addrOut = {upperQ, beatAddr};

  // R4
  upper_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    !strobes.load |=> $stable(addrOut[ADDR_W-1:BEAT_W]));

  // R5
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (!strobes.load && !strobes.advance) |=> $stable(addrOut));

  // R9
  load_takes_bus_chk: assert property (@(posedge clk) disable iff (rst)
    strobes.load |=> (addrOut == $past(addrIn)));

  // R7
  linear_step_chk: assert property (@(posedge clk) disable iff (rst)
    (strobes.advance && !modeIlQ) |=>
      (addrOut[BEAT_W-1:0] == $past(addrOut[BEAT_W-1:0]) + 1'b1));
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W = 18
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic              procLoadN,
  input  logic              cacheLoadN,
  input  logic              chipEnN,
  input  logic              advanceN,
  input  logic              orderIl,
  output logic [ADDR_W-1:0] addrOut
);
  seqStrobes_t strobes;

  burst_seq_ctrl i_ctrl (
    .procLoadN  (procLoadN),
    .cacheLoadN (cacheLoadN),
    .chipEnN    (chipEnN),
    .advanceN   (advanceN),
    .strobes    (strobes)
  );

  burst_seq_dp #(.ADDR_W(ADDR_W)) i_dp (
    .clk     (clk),
    .rst     (rst),
    .strobes (strobes),
    .addrIn  (addrIn),
    .orderIl (orderIl),
    .addrOut (addrOut)
  );
endmodule

// File: tb/test_burst_addr_seq.sv
`timescale 1ns/100ps
module test_burst_addr_seq;
  localparam int ADDR_W = 18;

  logic              clk = 1'b0;
  logic              rst;
  logic [ADDR_W-1:0] addrIn;
  logic              procLoadN, cacheLoadN, chipEnN, advanceN, orderIl;
  logic [ADDR_W-1:0] addrOut;

  int vectors = 0;
  int misses  = 0;

  // Behavioural reference state.
  int refUpper = 0;
  int refBase  = 0;
  int refK     = 0;
  int refIl    = 0;

  always #2.5 clk = ~clk;

  burst_addr_seq #(.ADDR_W(ADDR_W)) i_burst_addr_seq (
    .clk(clk), .rst(rst), .addrIn(addrIn), .procLoadN(procLoadN),
    .cacheLoadN(cacheLoadN), .chipEnN(chipEnN), .advanceN(advanceN),
    .orderIl(orderIl), .addrOut(addrOut)
  );

  function automatic int expected();
    int lowBits;
    if (refIl != 0) lowBits = refBase ^ refK;
    else            lowBits = (refBase + refK) % 4;
    return refUpper * 4 + lowBits;
  endfunction

  // Apply one cycle: inputs are set now (away from the edge), the model
  // updates at the rising edge, and the output is compared at the falling edge.
  task automatic cyc(input bit r, input bit cN, input bit pN, input bit ceN,
                     input bit aN, input bit il, input int addr, input string tag);
    int exp;
    rst = r; cacheLoadN = cN; procLoadN = pN; chipEnN = ceN;
    advanceN = aN; orderIl = il; addrIn = addr[ADDR_W-1:0];
    @(posedge clk);
    if (r) begin
      refUpper = 0; refBase = 0; refK = 0; refIl = 0;
    end else if (!cN || (!pN && !ceN)) begin
      refUpper = addr[ADDR_W-1:0] / 4; refBase = addr % 4; refK = 0; refIl = il;
    end else if (!aN) begin
      refK = (refK + 1) % 4;
    end
    @(negedge clk);
    exp = expected();
    vectors++;
    if (addrOut !== exp[ADDR_W-1:0]) begin
      misses++;
      $display("FAIL %s: addrOut=%h expected %h", tag, addrOut, exp[ADDR_W-1:0]);
    end
  endtask

  initial begin
    #(5.0 * 200000);
    misses++;
    $display("FAIL watchdog: run did not finish");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    @(negedge clk);
    // R1: reset state
    cyc(1, 1, 1, 1, 1, 0, 'h3ffff, "R1 reset");
    cyc(1, 1, 1, 1, 1, 0, 'h3ffff, "R1 reset hold");
    // R1: after reset, an advance steps linearly from zero
    cyc(0, 1, 1, 1, 0, 1, 'h12345, "R1 step from zero");
    // R2: cache load with chip disabled, linear start 10
    cyc(0, 0, 1, 1, 1, 0, 'h2aaa6, "R2 cache load");
    // R7, R4: linear beats with a changing bus
    cyc(0, 1, 1, 1, 0, 0, 'h01111, "R7 beat 2");
    cyc(0, 1, 1, 1, 0, 0, 'h3fffc, "R7 beat 3");
    cyc(0, 1, 1, 1, 0, 0, 'h00000, "R7 beat 4");
    // R8: wrap back to start
    cyc(0, 1, 1, 1, 0, 0, 'h15555, "R8 linear wrap");
    // R5: hold
    cyc(0, 1, 1, 1, 1, 0, 'h0abcd, "R5 hold");
    cyc(0, 1, 1, 1, 1, 1, 'h0abcd, "R5 hold again");
    // R3: processor load while chip disabled is ignored
    cyc(0, 1, 0, 1, 1, 0, 'h00005, "R3 ignored");
    cyc(0, 1, 0, 1, 0, 0, 'h00005, "R3 ignored with advance");
    // R3: processor load with chip enabled; R6: interleaved start 01
    cyc(0, 1, 0, 0, 1, 1, 'h1c3c1, "R3 proc load");
    cyc(0, 1, 1, 0, 0, 1, 'h00000, "R6 beat 2");
    // R10: order select flips mid-burst, order must stay interleaved
    cyc(0, 1, 1, 0, 0, 0, 'h3ffff, "R10 beat 3");
    cyc(0, 1, 1, 0, 0, 0, 'h3ffff, "R10 beat 4");
    cyc(0, 1, 1, 0, 0, 0, 'h3ffff, "R8 interleave wrap");
    // R6: interleaved start 11 with a suspend
    cyc(0, 0, 1, 1, 1, 1, 'h20003, "R6 load 11");
    cyc(0, 1, 1, 1, 0, 1, 'h0, "R6 k1");
    cyc(0, 1, 1, 1, 1, 1, 'h0, "R5 suspend");
    cyc(0, 1, 1, 1, 0, 1, 'h0, "R6 k2");
    cyc(0, 1, 1, 1, 0, 1, 'h0, "R6 k3");
    // R9: load together with advance
    cyc(0, 0, 1, 1, 0, 0, 'h13579, "R9 load beats advance");
    cyc(0, 1, 0, 0, 0, 1, 'h2468a, "R9 proc load with advance");
    cyc(0, 1, 1, 1, 0, 1, 'h0, "R6 after R9");
    // R1: reset in mid-burst
    cyc(1, 1, 1, 1, 0, 1, 'h0, "R1 mid-burst reset");
    cyc(0, 1, 1, 1, 0, 1, 'h0, "R1 linear after reset");
    // Sweep every start value in both orders through a full wrap
    for (int m = 0; m < 2; m++) begin
      for (int s = 0; s < 4; s++) begin
        cyc(0, 0, 1, 1, 1, m[0], 'h10000 + s * 'h111 * 4 + s, m ? "R6 sweep load" : "R7 sweep load");
        for (int b = 0; b < 4; b++)
          cyc(0, 1, 1, 1, 0, m[0], b * 'h5a5, m ? "R6 R8 sweep" : "R7 R8 sweep");
      end
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule